// File: doc/BRIEF.md
# Event Timer Slice with Periodic Reload

This block is one slice of a high-precision event timer. It contains a free-running main counter, a global control word and a single timer channel, all reached through a plain 32-bit register port. The port has one write strobe, an address and write data. Reads are combinational on the address.

The channel compares the main counter against an absolute comparator. When the counter equals the comparator while counting is enabled, the channel raises a one-cycle interrupt pulse. In periodic mode it then advances the comparator by a separate period value.

Software can start a periodic timer while the counter is already well past zero. To do this it arms a self-clearing "load split" bit in the channel control word and then writes the comparator address twice. The first write sets the absolute match point (typically the current count plus the period). The second write sets only the period. A global flag, settable in the same write that restarts the counter, is driven out as a legacy-routing indication.

Top module: `evt_timer_slice`

## Requirements
- R1: After reset, every register reads zero except the identity word at 0x000, which reads 0x0000_8001: bit 15 is legacy-routing capability and bits [7:0] are the revision. `timer_irq` and `legacy_route` are low. Writes to 0x000 have no effect.
- R2: Global control at 0x010, bit 0 (run): while it is 1, the main counter advances by one every clock. While it is 0, the counter holds its value.
- R3: Global control bit 1 (legacy) drives `legacy_route`. It can be set in the same write as run, and both bits read back.
- R4: The main counter reads at 0x0F0. A write there loads the counter only while run is 0. A write while running is ignored.
- R5: Channel control at 0x100 has these bits: 2 (interrupt enable), 3 (periodic), 6 (load split) and 8 (32-bit mode). All of them can be written in one access and read back.
- R6: With load split not armed, a write to the comparator address 0x108 loads both the comparator and the period with the written value. Reads of 0x108 return the comparator.
- R7: When a channel control write has bit 6 set, the next comparator write loads only the comparator and the one after it loads only the period. Bit 6 reads 1 from the arming write until the period write, and reads 0 after it.
- R8: When run is 1 and the counter equals the comparator, `timer_irq` is high for exactly the following clock cycle. In that cycle the counter reads comparator+1.
- R9: In periodic mode, each interrupt adds the period to the comparator. Successive interrupts are therefore spaced by the period, modulo 2^32, including across counter wrap.
- R10: In one-shot mode (bit 3 clear), a match raises one interrupt and the comparator keeps its value.
- R11: With interrupt enable clear, a match raises no interrupt and does not advance the comparator.
- R12: If software writes the comparator in the same cycle as a periodic match, the written value is taken instead of the reload. The interrupt for that match still issues.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe, one access per cycle |
| bus_addr | input | ADDR_W (12) | Register byte address |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data for `bus_addr`; zero for unmapped addresses |
| timer_irq | output | 1 | One-cycle interrupt pulse on a channel match |
| legacy_route | output | 1 | Legacy-routing flag from the global control word |

## Verification
Two functions can fall into the same cycle: the periodic reload of the comparator on a match, and a software write to the comparator. The bench starts the counter from a known value and counts clocks so that the comparator write strobe lands on the exact edge where the counter equals the comparator. It then judges that the interrupt still appears and that the comparator reads the written value rather than the old match point plus the period. The periodic sweeps cover a second overlap: at a period of one, a reload falls on every cycle, and a pulse must follow every cycle with no gap.

// File: rtl/evt_timer_pkg.sv
package evt_timer_pkg;

   // register byte addresses (12-bit map)
   localparam logic [11:0] A_IDENT = 12'h000;
   localparam logic [11:0] A_GCTL  = 12'h010;
   localparam logic [11:0] A_COUNT = 12'h0F0;
   localparam logic [11:0] A_TCTL  = 12'h100;
   localparam logic [11:0] A_TCMP  = 12'h108;

   // global control bits
   localparam int unsigned G_RUN = 0;
   localparam int unsigned G_LEG = 1;

   // channel control bits
   localparam int unsigned T_IE  = 2;
   localparam int unsigned T_PER = 3;
   localparam int unsigned T_SPL = 6;
   localparam int unsigned T_M32 = 8;

   // identity capability bit
   localparam int unsigned I_LEG = 15;

   // load-split sequencing
   typedef enum logic [1:0] {
      SPL_IDLE  = 2'd0,
      SPL_ARMED = 2'd1,
      SPL_WPER  = 2'd2
   } spl_state_e;

endpackage

// File: rtl/evt_main_counter.sv
module evt_main_counter #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         run,
   input  logic         ld,
   input  logic [W-1:0] ld_val,
   output logic [W-1:0] cnt
);

   localparam logic [W-1:0] ONE = W'(1);

   always_ff @(posedge clk) begin
      if (!rst_n)      cnt <= '0;
      else if (ld)     cnt <= ld_val;
      else if (run)    cnt <= cnt + ONE;
   end

   // R2
   cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(run && !ld) |-> cnt == $past(cnt) + ONE);

   // R2
   cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!run && !ld) |-> cnt == $past(cnt));

endmodule

// File: rtl/evt_chan.sv
module evt_chan
   import evt_timer_pkg::*;
#(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] cnt,
   input  logic         run,
   input  logic         cfg_wr,
   input  logic         cfg_ie,
   input  logic         cfg_per,
   input  logic         cfg_spl,
   input  logic         cfg_m32,
   input  logic         cmp_wr,
   input  logic [W-1:0] cmp_wdata,
   output logic [W-1:0] cfg_rdata,
   output logic [W-1:0] cmp_q,
   output logic         irq
);

   logic       ie_q, per_q, m32_q;
   spl_state_e spl_q;
   logic [W-1:0] period_q;
   logic       fire;

   assign fire = run && ie_q && (cnt == cmp_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ie_q  <= 1'b0;
         per_q <= 1'b0;
         m32_q <= 1'b0;
      end else if (cfg_wr) begin
         ie_q  <= cfg_ie;
         per_q <= cfg_per;
         m32_q <= cfg_m32;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         spl_q <= SPL_IDLE;
      else if (cfg_wr && cfg_spl)
         spl_q <= SPL_ARMED;
      else if (cmp_wr) begin
         case (spl_q)
            SPL_ARMED: spl_q <= SPL_WPER;
            default:   spl_q <= SPL_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cmp_q    <= '0;
         period_q <= '0;
      end else if (cmp_wr) begin
         case (spl_q)
            SPL_ARMED: cmp_q <= cmp_wdata;
            SPL_WPER:  period_q <= cmp_wdata;
            default: begin
               cmp_q    <= cmp_wdata;
               period_q <= cmp_wdata;
            end
         endcase
      end else if (fire && per_q) begin
         cmp_q <= cmp_q + period_q;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) irq <= 1'b0;
      else        irq <= fire;
   end

   always_comb begin
      cfg_rdata        = '0;
      cfg_rdata[T_IE]  = ie_q;
      cfg_rdata[T_PER] = per_q;
      cfg_rdata[T_SPL] = (spl_q != SPL_IDLE);
      cfg_rdata[T_M32] = m32_q;
   end

   // R7
   split_period_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(cmp_wr) && $past(spl_q) == SPL_WPER) |-> (cmp_q == $past(cmp_q) && spl_q != SPL_WPER));

   // R9
   reload_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(fire && per_q && !cmp_wr) |-> cmp_q == $past(cmp_q) + $past(period_q));

   // R10
   oneshot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!per_q && !cmp_wr) |-> cmp_q == $past(cmp_q));

   // R11
   irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> $past(ie_q && run));

   // R12
   write_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(cmp_wr && spl_q == SPL_IDLE) |-> cmp_q == $past(cmp_wdata));

endmodule

// File: rtl/evt_timer_slice.sv
module evt_timer_slice
   import evt_timer_pkg::*;
#(
   parameter int        ADDR_W     = 12,
   parameter int        DATA_W     = 32,
   parameter bit        LEGACY_CAP = 1'b1,
   parameter logic [7:0] REV_ID    = 8'h01
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              timer_irq,
   output logic              legacy_route
);

   if (ADDR_W < 9) begin : g_bad_addr
      $error("ADDR_W too small for the register map");
   end
   if (DATA_W < 16) begin : g_bad_data
      $error("DATA_W must hold the identity capability bit");
   end

   localparam logic [ADDR_W-1:0] AD_IDENT = ADDR_W'(A_IDENT);
   localparam logic [ADDR_W-1:0] AD_GCTL  = ADDR_W'(A_GCTL);
   localparam logic [ADDR_W-1:0] AD_COUNT = ADDR_W'(A_COUNT);
   localparam logic [ADDR_W-1:0] AD_TCTL  = ADDR_W'(A_TCTL);
   localparam logic [ADDR_W-1:0] AD_TCMP  = ADDR_W'(A_TCMP);

   logic sel_id, sel_g, sel_c, sel_t, sel_m;
   logic run_q, leg_q;
   logic [DATA_W-1:0] cnt, cmp, tcfg_rd, ident;

   assign sel_id = (bus_addr == AD_IDENT);
   assign sel_g  = (bus_addr == AD_GCTL);
   assign sel_c  = (bus_addr == AD_COUNT);
   assign sel_t  = (bus_addr == AD_TCTL);
   assign sel_m  = (bus_addr == AD_TCMP);

   always_ff @(posedge clk) begin
      if (!rst_n)              run_q <= 1'b0;
      else if (bus_wr && sel_g) run_q <= bus_wdata[G_RUN];
   end

   if (LEGACY_CAP) begin : g_leg
      always_ff @(posedge clk) begin
         if (!rst_n)              leg_q <= 1'b0;
         else if (bus_wr && sel_g) leg_q <= bus_wdata[G_LEG];
      end
   end else begin : g_noleg
      assign leg_q = 1'b0;
   end

   assign legacy_route = leg_q;

   always_comb begin
      ident        = '0;
      ident[7:0]   = REV_ID;
      ident[I_LEG] = LEGACY_CAP;
   end

   evt_main_counter #(.W(DATA_W)) u_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .run    (run_q),
      .ld     (bus_wr && sel_c && !run_q),
      .ld_val (bus_wdata),
      .cnt    (cnt)
   );

   evt_chan #(.W(DATA_W)) u_chan (
      .clk       (clk),
      .rst_n     (rst_n),
      .cnt       (cnt),
      .run       (run_q),
      .cfg_wr    (bus_wr && sel_t),
      .cfg_ie    (bus_wdata[T_IE]),
      .cfg_per   (bus_wdata[T_PER]),
      .cfg_spl   (bus_wdata[T_SPL]),
      .cfg_m32   (bus_wdata[T_M32]),
      .cmp_wr    (bus_wr && sel_m),
      .cmp_wdata (bus_wdata),
      .cfg_rdata (tcfg_rd),
      .cmp_q     (cmp),
      .irq       (timer_irq)
   );

   always_comb begin
      bus_rdata = '0;
      if (sel_id)     bus_rdata = ident;
      else if (sel_g) begin
         bus_rdata[G_RUN] = run_q;
         bus_rdata[G_LEG] = leg_q;
      end
      else if (sel_c) bus_rdata = cnt;
      else if (sel_t) bus_rdata = tcfg_rd;
      else if (sel_m) bus_rdata = cmp;
   end

   // R4
   running_load_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(run_q && bus_wr && sel_c) |-> cnt == $past(cnt) + DATA_W'(1));

   // R3
   legacy_follows_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(bus_wr && sel_g) |-> legacy_route == ($past(bus_wdata[G_LEG]) && LEGACY_CAP));

endmodule

// File: tb/test_evt_timer_slice.sv
module test_evt_timer_slice;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [11:0] bus_addr = 12'h000;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        timer_irq;
   logic        legacy_route;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   evt_timer_slice i_evt_timer_slice (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .timer_irq(timer_irq), .legacy_route(legacy_route)
   );

   localparam logic [11:0] ID = 12'h000, GC = 12'h010, CN = 12'h0F0, TC = 12'h100, TM = 12'h108;
   localparam logic [31:0] IE = 32'h4, PER = 32'h8, SPL = 32'h40, M32 = 32'h100;

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
      end
   endtask

   // caller sits at a negedge; the write lands on the next posedge
   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(posedge clk);
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [11:0] a, output logic [31:0] d);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   // periodic sweep through the split-load protocol
   task automatic sweep(input logic [31:0] start, input logic [31:0] off, input logic [31:0] p, input int n);
      logic [31:0] v, exp;
      int got, want;
      wr(GC, 0);
      wr(CN, start);
      wr(TC, IE | PER | SPL);
      wr(TM, start + off);
      wr(TM, p);
      wr(GC, 1);
      exp = start + off;
      got = 0;
      for (int k = 1; k <= n; k++) begin
         @(negedge clk);
         rd(CN, v);
         chk(v == start + 32'(k), "R2 count step", v, start + 32'(k));
         if (timer_irq) begin
            chk(v == exp + 1, "R9 periodic spacing", v, exp + 1);
            exp = exp + p;
            got++;
         end
      end
      want = (int'(off) <= n - 1) ? ((n - 1 - int'(off)) / int'(p) + 1) : 0;
      chk(got == want, "R8 pulse count", 32'(got), 32'(want));
   endtask

   initial begin
      #(200000 * 4);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog actual=%08h expected=%08h", 32'd0, 32'd1);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      logic [31:0] v, s;
      int n;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rd(ID, v); chk(v == 32'h0000_8001, "R1 ident", v, 32'h0000_8001);
      rd(GC, v); chk(v == 0, "R1 gctl", v, 0);
      rd(CN, v); chk(v == 0, "R1 count", v, 0);
      rd(TC, v); chk(v == 0, "R1 tctl", v, 0);
      rd(TM, v); chk(v == 0, "R1 cmp", v, 0);
      chk(timer_irq == 0, "R1 irq", 32'(timer_irq), 0);
      chk(legacy_route == 0, "R1 legacy", 32'(legacy_route), 0);
      @(negedge clk);
      wr(ID, 32'hFFFF_FFFF);
      rd(ID, v); chk(v == 32'h0000_8001, "R1 ident write ignored", v, 32'h0000_8001);

      // R3 legacy with run in one write
      @(negedge clk);
      wr(GC, 3);
      chk(legacy_route == 1, "R3 legacy set", 32'(legacy_route), 1);
      rd(GC, v); chk(v == 3, "R3 gctl readback", v, 3);
      @(negedge clk);
      wr(GC, 0);
      chk(legacy_route == 0, "R3 legacy clear", 32'(legacy_route), 0);

      // R2 hold while stopped
      rd(CN, s);
      repeat (5) @(negedge clk);
      rd(CN, v); chk(v == s, "R2 hold", v, s);

      // R4 load while stopped, ignored while running
      @(negedge clk);
      wr(CN, 32'h0000_1000);
      rd(CN, v); chk(v == 32'h1000, "R4 load stopped", v, 32'h1000);
      @(negedge clk);
      wr(GC, 1);
      wr(CN, 32'hDEAD_0000);
      rd(CN, v); chk(v == 32'h1001, "R4 load running ignored", v, 32'h1001);
      @(negedge clk);
      wr(GC, 0);

      // R5 + R7 split-load protocol
      wr(CN, 32'h100);
      wr(TC, IE | PER | SPL | M32);
      rd(TC, v); chk(v == 32'h14C, "R5 tctl readback", v, 32'h14C);
      @(negedge clk);
      wr(TM, 32'h10A);
      rd(TC, v); chk(v[6] == 1, "R7 split still armed", v, 32'h14C);
      rd(TM, v); chk(v == 32'h10A, "R7 cmp loaded", v, 32'h10A);
      @(negedge clk);
      wr(TM, 32'h4);
      rd(TC, v); chk(v == 32'h10C, "R7 split self-cleared", v, 32'h10C);
      rd(TM, v); chk(v == 32'h10A, "R7 cmp untouched by period write", v, 32'h10A);

      // R6 plain write loads both
      @(negedge clk);
      wr(CN, 0);
      wr(TC, IE | PER);
      wr(TM, 7);
      rd(TM, v); chk(v == 7, "R6 cmp plain write", v, 7);
      @(negedge clk);
      wr(GC, 1);
      n = 0;
      for (int k = 1; k <= 20; k++) begin
         @(negedge clk);
         rd(CN, v);
         if (timer_irq) begin
            chk(v == 32'(7 * (n + 1) + 1), "R6 period equals written value", v, 32'(7 * (n + 1) + 1));
            n++;
         end
      end
      chk(n == 2, "R6 pulse count", 32'(n), 2);
      rd(TM, v); chk(v == 21, "R9 cmp advanced", v, 21);
      @(negedge clk);
      wr(GC, 0);

      // R10 one-shot
      wr(CN, 32'h200);
      wr(TC, IE);
      wr(TM, 32'h205);
      wr(GC, 1);
      n = 0;
      for (int k = 1; k <= 20; k++) begin
         @(negedge clk);
         if (timer_irq) n++;
      end
      chk(n == 1, "R10 one pulse", 32'(n), 1);
      rd(TM, v); chk(v == 32'h205, "R10 cmp kept", v, 32'h205);
      @(negedge clk);
      wr(GC, 0);

      // R11 enable clear
      wr(CN, 32'h300);
      wr(TC, PER);
      wr(TM, 32'h303);
      wr(GC, 1);
      n = 0;
      for (int k = 1; k <= 12; k++) begin
         @(negedge clk);
         if (timer_irq) n++;
      end
      chk(n == 0, "R11 no pulse", 32'(n), 0);
      rd(TM, v); chk(v == 32'h303, "R11 no reload", v, 32'h303);
      @(negedge clk);
      wr(GC, 0);

      // R12 write on the match edge
      wr(CN, 32'h40);
      wr(TC, IE | PER | SPL);
      wr(TM, 32'h45);
      wr(TM, 32'h3);
      wr(GC, 1);
      repeat (5) @(negedge clk);
      wr(TM, 32'h60);
      chk(timer_irq == 1, "R12 pulse kept", 32'(timer_irq), 1);
      rd(TM, v); chk(v == 32'h60, "R12 write wins", v, 32'h60);
      @(negedge clk);
      wr(GC, 0);

      // R8/R9 sweeps including wrap
      for (int p = 1; p <= 6; p++) begin
         sweep(32'h0000_0010, 3, 32'(p), 24);
         sweep(32'hFFFF_FFF4, 3, 32'(p), 24);
      end
      // R8 match on the very first running cycle
      sweep(32'h0000_0500, 0, 32'd5, 12);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule